// File: doc/BRIEF.md
# Falling-Edge Interrupt Request Controller

This block gathers interrupt requests for a small 8-bit controller core and tells the fetch unit when, and to which address, it must jump. Seven sources feed it: a timer overflow, two 8-bit counter overflows, and four external pins that arrive on the low nibble of an input port. Every source requests on a high-to-low transition. A request is latched into a status register only when the matching bit of a mask register is set. Flags are never cleared by hardware. Software clears them through a register write.

A global enable sits above the mask. The enable-interrupts instruction sets it and the disable-interrupts instruction clears it. While it is set and any masked flag is pending, the block raises a vector request toward 0x008. Accepting that vector clears the global enable, which blocks nested entry. A software-interrupt instruction requests vector 0x001. The first cycle after reset requests vector 0x000. The external pins stay readable as plain synchronized data whatever their mask bits hold.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, the status and mask registers read 0x00. A vector request with address 0x000 appears exactly once, in the first cycle after the internal reset releases.
- R2: A falling edge on an enabled source sets its status bit three clock edges after the input changes. The bit positions are: timer 0, counter A 1, counter B 2, external pins 0..3 at bits 3..6. A rising edge sets nothing.
- R3: A falling edge on a source whose mask bit is 0 leaves its status bit at 0. Setting the mask bit afterwards does not recover that edge.
- R4: `pin_data_o` shows the external pins after a two-flop synchronizer (two clock edges of latency), whatever the mask holds.
- R5: Once set, a status bit stays set until software clears it. A status write (`reg_sel_i`=0) clears each bit written as 0 and keeps each bit written as 1. A write can never set a bit.
- R6: If a status clear and a new falling edge on the same source fall in the same cycle, the flag ends up set.
- R7: A mask write (`reg_sel_i`=1) loads all 8 bits, which read back on `mask_o`. Only flags that are both set and masked request a vector.
- R8: `irq_en_i` sets the global enable and `irq_dis_i` clears it, with the clear taking priority. While the enable is set and a masked flag is pending, the block requests address 0x008.
- R9: Issuing the 0x008 request clears the global enable, so the request lasts a single cycle. A flag left set causes a new 0x008 request once the enable is set again.
- R10: `sw_irq_i` requests address 0x001 in the same cycle, whatever the global enable holds. It takes priority over a hardware request, which is then deferred to a later cycle with the enable left set.
- R11: Status bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_ovf_i | input | 1 | Timer overflow source, falling-edge active |
| cnta_ovf_i | input | 1 | Counter A overflow source, falling-edge active |
| cntb_ovf_i | input | 1 | Counter B overflow source, falling-edge active |
| ext_pin_i | input | 4 | External interrupt pins (port bits 0..3) |
| pin_data_o | output | 4 | Synchronized external pin values as general input data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = status (write-to-clear), 1 = mask |
| reg_wdata_i | input | 8 | Write data |
| status_o | output | 8 | Status (flag) register |
| mask_o | output | 8 | Mask register |
| irq_en_i | input | 1 | Enable-interrupts instruction strobe |
| irq_dis_i | input | 1 | Disable-interrupts instruction strobe |
| sw_irq_i | input | 1 | Software-interrupt instruction strobe |
| vec_req_o | output | 1 | Vector request to fetch unit |
| vec_addr_o | output | 12 | Vector address (0x000, 0x001 or 0x008) |

## Verification
Falling edges go to enabled and to disabled sources, and rising edges to enabled ones. This shows that mask gating happens at edge time and that polarity matters. Status writes with mixed bit patterns check clear-only behaviour. One clear is timed into the same cycle as a fresh edge to show that the edge wins. The vector scoreboard is fed several instruction sequences: enable with a pending flag, re-enable with the flag still set, disable before the mask opens, and a software interrupt alone and alongside a hardware request. These sequences separate the priority order, the one-cycle request and the clearing of the enable.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC   = 7;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned NEXT   = 4;

  localparam int unsigned BIT_TMR  = 0;
  localparam int unsigned BIT_CNTA = 1;
  localparam int unsigned BIT_CNTB = 2;
  localparam int unsigned BIT_EXT0 = 3;

  localparam logic [ADDR_W-1:0] VEC_RESET = 12'h000;
  localparam logic [ADDR_W-1:0] VEC_SOFT  = 12'h001;
  localparam logic [ADDR_W-1:0] VEC_HW    = 12'h008;

  typedef enum logic [1:0] {
    VK_NONE  = 2'd0,
    VK_RESET = 2'd1,
    VK_SOFT  = 2'd2,
    VK_HW    = 2'd3
  } vec_kind_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_src
    logic meta_q, sync_q, dly_q;
    logic meta_d, sync_d, dly_d;

    always_comb begin
      meta_d = src_i[g];
      sync_d = meta_q;
      dly_d  = sync_q;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        dly_q  <= 1'b0;
      end else begin
        meta_q <= meta_d;
        sync_q <= sync_d;
        dly_q  <= dly_d;
      end
    end

    assign sync_o[g] = sync_q;
    assign fall_o[g] = dly_q & ~sync_q;
  end
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  fall_i,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] status_o,
  output logic [REG_W-1:0] mask_o
);
  localparam int unsigned PAD = REG_W - NSRC;

  logic [NSRC-1:0]  flag_q, flag_d;
  logic [REG_W-1:0] mask_q, mask_d;
  logic             mask_en, clr_en;
  logic [NSRC-1:0]  set_vec, keep_vec;

  always_comb begin
    clr_en   = wr_i & ~sel_i;
    mask_en  = wr_i & sel_i;
    set_vec  = fall_i & mask_q[NSRC-1:0];
    keep_vec = clr_en ? wdata_i[NSRC-1:0] : {NSRC{1'b1}};
    flag_d   = (flag_q & keep_vec) | set_vec;
    mask_d   = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign status_o = {{PAD{1'b0}}, flag_q};
  assign mask_o   = mask_q;
endmodule

// File: rtl/irq_vector.sv
module irq_vector
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              pending_i,
  input  logic              en_i,
  input  logic              dis_i,
  input  logic              sw_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic      boot_q, boot_d;
  logic      gie_q, gie_d;
  vec_kind_e kind;

  always_comb begin
    if (boot_q)                 kind = VK_RESET;
    else if (sw_i)              kind = VK_SOFT;
    else if (gie_q & pending_i) kind = VK_HW;
    else                        kind = VK_NONE;

    boot_d = 1'b0;
    if (dis_i || kind == VK_HW) gie_d = 1'b0;
    else if (en_i)              gie_d = 1'b1;
    else                        gie_d = gie_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= 1'b1;
      gie_q  <= 1'b0;
    end else begin
      boot_q <= boot_d;
      gie_q  <= gie_d;
    end
  end

  always_comb begin
    req_o = rst_ni && (kind != VK_NONE);
    unique case (kind)
      VK_RESET: addr_o = VEC_RESET;
      VK_SOFT:  addr_o = VEC_SOFT;
      VK_HW:    addr_o = VEC_HW;
      default:  addr_o = VEC_RESET;
    endcase
  end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_ovf_i,
  input  logic              cnta_ovf_i,
  input  logic              cntb_ovf_i,
  input  logic [3:0]        ext_pin_i,
  output logic [3:0]        pin_data_o,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        status_o,
  output logic [7:0]        mask_o,
  input  logic              irq_en_i,
  input  logic              irq_dis_i,
  input  logic              sw_irq_i,
  output logic              vec_req_o,
  output logic [11:0]       vec_addr_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [NSRC-1:0] src, sync, fall;
  logic            pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    src = '0;
    src[BIT_TMR]  = tmr_ovf_i;
    src[BIT_CNTA] = cnta_ovf_i;
    src[BIT_CNTB] = cntb_ovf_i;
    src[BIT_EXT0 +: NEXT] = ext_pin_i;
  end

  irq_edge_sync #(.W(NSRC)) u_sync (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .src_i  (src),
    .sync_o (sync),
    .fall_o (fall)
  );

  assign pin_data_o = sync[BIT_EXT0 +: NEXT];

  irq_flag_regs u_regs (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .fall_i   (fall),
    .wr_i     (reg_wr_i),
    .sel_i    (reg_sel_i),
    .wdata_i  (reg_wdata_i),
    .status_o (status_o),
    .mask_o   (mask_o)
  );

  assign pending = |(status_o & mask_o);

  irq_vector u_vec (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .pending_i (pending),
    .en_i      (irq_en_i),
    .dis_i     (irq_dis_i),
    .sw_i      (sw_irq_i),
    .req_o     (vec_req_o),
    .addr_o    (vec_addr_o)
  );
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_i,
  input logic        reg_sel_i,
  input logic [7:0]  status_o,
  input logic [7:0]  mask_o,
  input logic        irq_dis_i,
  input logic        vec_req_o,
  input logic [11:0] vec_addr_o
);
  // R3
  flag_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(mask_o)) == 8'h00));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && !reg_sel_i) |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R9
  hw_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req_o && vec_addr_o == 12'h008) |=> !(vec_req_o && vec_addr_o == 12'h008));

  // R8
  dis_blocks_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dis_i |=> !(vec_req_o && vec_addr_o == 12'h008));

  // R11
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] == 1'b0);

  // R10
  legal_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req_o |-> (vec_addr_o == 12'h000 || vec_addr_o == 12'h001 || vec_addr_o == 12'h008));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_i   (reg_wr_i),
  .reg_sel_i  (reg_sel_i),
  .status_o   (status_o),
  .mask_o     (mask_o),
  .irq_dis_i  (irq_dis_i),
  .vec_req_o  (vec_req_o),
  .vec_addr_o (vec_addr_o)
);

// File: tb/edge_irq_ctrl_tb_top.sv
module edge_irq_ctrl_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tmr, cnta, cntb;
  logic [3:0]  ext;
  logic [3:0]  pin_data;
  logic        wr, sel;
  logic [7:0]  wdata;
  logic [7:0]  status, mask;
  logic        en, dis, sw;
  logic        vreq;
  logic [11:0] vaddr;

  int total = 0;
  int bad   = 0;
  logic [11:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  edge_irq_ctrl dut_i (
    .clk (clk), .rst_n (rst_n),
    .tmr_ovf_i (tmr), .cnta_ovf_i (cnta), .cntb_ovf_i (cntb),
    .ext_pin_i (ext), .pin_data_o (pin_data),
    .reg_wr_i (wr), .reg_sel_i (sel), .reg_wdata_i (wdata),
    .status_o (status), .mask_o (mask),
    .irq_en_i (en), .irq_dis_i (dis), .sw_irq_i (sw),
    .vec_req_o (vreq), .vec_addr_o (vaddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_write(input logic s, input logic [7:0] d);
    wr = 1'b1; sel = s; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic pulse_en();
    en = 1'b1; tick(); en = 1'b0;
  endtask

  // Scoreboard monitor: every vector request must match the next expected address
  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n === 1'b1 && vreq === 1'b1) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R8 actual=unexpected vector %h expected=none", vaddr);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk("R1/R8/R10 vector address", {20'h0, vaddr}, {20'h0, e});
      end
    end
  end

  initial begin
    #(CLK_P*200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tmr = 1'b1; cnta = 1'b1; cntb = 1'b1; ext = 4'hF;
    wr = 1'b0; sel = 1'b0; wdata = 8'h00; en = 1'b0; dis = 1'b0; sw = 1'b0;
    exp_q.push_back(12'h000);                // R1 reset vector once
    tick(3);
    rst_n = 1'b1;
    tick(5);
    chk("R1 status", {24'h0, status}, 32'h00);
    chk("R1 mask",   {24'h0, mask},   32'h00);

    // R4 pins as data, R3 masked-off edges ignored
    ext = 4'b1010;
    tick(2);
    chk("R4 pin data", {28'h0, pin_data}, 32'hA);
    tick(2);
    chk("R3 masked edge", {24'h0, status}, 32'h00);
    ext = 4'hF;
    tick(3);

    // R7 mask load
    reg_write(1'b1, 8'h7F);
    chk("R7 mask readback", {24'h0, mask}, 32'h7F);
    chk("R3 late mask", {24'h0, status}, 32'h00);

    // R2 falling edges set flags, rising does not
    tmr = 1'b0; tick(3);
    chk("R2 timer bit0", {24'h0, status}, 32'h01);
    tmr = 1'b1; tick(3);
    chk("R2 rising no set", {24'h0, status}, 32'h01);
    cntb = 1'b0; tick(3);
    chk("R2 counter B bit2", {24'h0, status}, 32'h05);
    ext[3] = 1'b0; tick(3);
    chk("R2 pin3 bit6", {24'h0, status}, 32'h45);
    cntb = 1'b1; ext[3] = 1'b1; tick(3);

    // R5 write-to-clear, R11 bit 7
    reg_write(1'b0, 8'hFB);
    chk("R5 clear bit2", {24'h0, status}, 32'h41);
    reg_write(1'b0, 8'hFF);
    chk("R5 no set by write", {24'h0, status}, 32'h41);
    chk("R11 bit7 zero", {31'h0, status[7]}, 32'h0);
    reg_write(1'b0, 8'h00);
    chk("R5 clear all", {24'h0, status}, 32'h00);

    // R6 edge beats same-cycle clear
    cnta = 1'b0; tick(2);
    reg_write(1'b0, 8'h00);
    chk("R6 edge wins", {24'h0, status}, 32'h02);
    reg_write(1'b0, 8'h00);
    cnta = 1'b1; tick(3);
    chk("R5 cleared", {24'h0, status}, 32'h00);

    // R8 enable with pending flag
    tmr = 1'b0; tick(3); tmr = 1'b1;
    tick(3);
    exp_q.push_back(12'h008);
    pulse_en();
    tick(3);
    chk("R9 flag kept after vector", {24'h0, status}, 32'h01);
    exp_q.push_back(12'h008);                // R9 re-enable retakes
    pulse_en();
    tick(3);

    // R8 disable wins; R7 unmasked flag does not request
    reg_write(1'b1, 8'h7E);
    pulse_en();
    dis = 1'b1; tick(); dis = 1'b0;
    reg_write(1'b1, 8'h7F);
    tick(3);
    exp_q.push_back(12'h008);
    pulse_en();
    tick(3);

    // R10 software vector with enable off, then alongside hardware
    exp_q.push_back(12'h001);
    sw = 1'b1; tick(); sw = 1'b0;
    tick(2);
    exp_q.push_back(12'h001);
    exp_q.push_back(12'h008);
    en = 1'b1; tick(); en = 1'b0;
    sw = 1'b1; tick(); sw = 1'b0;
    tick(3);

    // Clear flag: enable alone must not vector
    reg_write(1'b0, 8'h00);
    pulse_en();
    tick(4);
    chk("R8 all expected vectors seen", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule